// File: doc/BRIEF.md
# Charge Cycle Sequencer

This block is the digital control state machine of a single-cell lithium battery charger. Its inputs are comparator flags that have already been digitized: supply valid, battery below the short threshold, battery below the recharge threshold, charge current below the termination level, and sleep. It also takes a disable pin and three control bits from a register interface: an active-low charge enable, a high-impedance request and a termination enable. From these it steps a charge cycle through supply validation, precharge, fast charge, termination, a battery-detection window, done and recharge. It drives the enable of the linear precharge source, the PWM stage and the detection sink, together with an active-low status output.

Every duration is a count of a one-millisecond tick input. Each transition that needs a stable flag has its own deglitch counter. A counter reloads from zero whenever its flag drops before expiry. A long safety timer backs up the host. The disable pin clears that timer, but the charge-enable and high-impedance bits do not.

Top module: `cell_chg_seq`

## Requirements
- R1: No enable output goes high until the supply flag has been valid for VALID_MS consecutive ticks; the block moves to precharge on the clock edge after the VALID_MS-th ticked edge. Losing the supply flag turns every enable off on the next edge and restarts validation.
- R2: While the short flag is 1 only the precharge source is on (PWM off). While it is 0 the PWM stage is on and the precharge source is off.
- R3: Termination needs the termination-enable bit at 1 and the low-current flag held for TERM_MS consecutive ticks; a drop of the flag reloads the count. With the bit at 0 the PWM stage stays on indefinitely.
- R4: After termination the detection sink alone is on for DET_MS ticks. The block then enters done, with all enables off.
- R5: In done, the recharge flag held for RCH_MS consecutive ticks (reloading on any drop) starts a new cycle through precharge.
- R6: The high-impedance bit at 1 turns all enables off on the next edge. Clearing it starts a new cycle.
- R7: The charge-enable bit at 1 (charging disabled) or the disable pin at 1 turns all enables off. Returning both to 0 starts a new cycle.
- R8: Ticks spent in precharge or fast charge accumulate in a safety timer. At SAFE_MS the block enters a fault with all enables off, and stays there until a new cycle starts. Only the disable pin or supply loss clears this timer; toggling the charge-enable bit does not.
- R9: The sleep flag at 1 stops charging on the next edge. Charging resumes only after the flag has been 0 for SLP_MS consecutive ticks.
- R10: The status output is 0 exactly when the precharge source or the PWM stage is on, and 1 otherwise, including during reset.
- R11: Timers advance only on clock edges where the tick input is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-millisecond time base strobe |
| vbus_ok_i | input | 1 | Input supply valid flag |
| bat_short_i | input | 1 | Battery below short-circuit threshold |
| bat_rch_i | input | 1 | Battery below recharge threshold |
| iterm_low_i | input | 1 | Charge current below termination level |
| sleep_i | input | 1 | Supply not above battery (sleep condition) |
| dis_i | input | 1 | Charge disable pin |
| ce_n_i | input | 1 | Charge enable bit, active low |
| hz_i | input | 1 | High-impedance request bit |
| te_i | input | 1 | Termination enable bit |
| lin_en_o | output | 1 | Linear precharge source enable |
| pwm_en_o | output | 1 | PWM stage enable |
| det_en_o | output | 1 | Battery-detection sink enable |
| stat_n_o | output | 1 | Status, low while charging |

## Verification
The hardest situation to reach is telling apart the two ways a safety-timer restart can happen. A disable-pin pulse clears the accumulated time, while a charge-enable toggle does not, and both look the same at the outputs while they are applied. The bench runs the safety limit short and charges for most of it. It then applies one kind of pulse and charges again for a span that the limit would only exceed if the earlier time were still counted. Whether the PWM enable is still high at that point shows whether the time was kept or cleared. Deglitch reloads get the same treatment: a flag is dropped after part of its window, and the total time held reaches the limit but no single run does.

// File: rtl/cell_chg_seq_pkg.sv
package cell_chg_seq_pkg;

  typedef enum logic [2:0] {
    PH_WAIT  = 3'd0,
    PH_PRE   = 3'd1,
    PH_FAST  = 3'd2,
    PH_DET   = 3'd3,
    PH_DONE  = 3'd4,
    PH_OFF   = 3'd5,
    PH_SLEEP = 3'd6,
    PH_FAULT = 3'd7
  } phase_e;

  typedef struct packed {
    logic lin;
    logic pwm;
    logic det;
  } drv_t;

  // Enables driven in each phase.
  function automatic drv_t phase_drive(phase_e p);
    drv_t d;
    d.lin = (p == PH_PRE);
    d.pwm = (p == PH_FAST);
    d.det = (p == PH_DET);
    return d;
  endfunction

  // Phases that count as charging for the status pin and the safety timer.
  function automatic logic phase_charging(phase_e p);
    return (p == PH_PRE) || (p == PH_FAST);
  endfunction

  // Bits needed for a counter that must reach lim.
  function automatic int unsigned cnt_bits(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/ccs_dglt.sv
module ccs_dglt #(
  parameter int unsigned LIMIT = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic arm_i,
  output logic hit_o
);
  localparam int unsigned W = cell_chg_seq_pkg::cnt_bits(LIMIT);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!arm_i) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q != LIM)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit_o = arm_i && (cnt_q == LIM);
endmodule

// File: rtl/ccs_safety.sv
module ccs_safety #(
  parameter int unsigned LIMIT = 900000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic clr_i,
  output logic expire_o
);
  localparam int unsigned W = cell_chg_seq_pkg::cnt_bits(LIMIT);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (run_i && tick_i && (cnt_q != LIM)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = (cnt_q == LIM);
endmodule

// File: rtl/ccs_next.sv
module ccs_next
  import cell_chg_seq_pkg::*;
(
  input  phase_e phase_i,
  input  logic   vbus_ok_i,
  input  logic   blocked_i,
  input  logic   bat_short_i,
  input  logic   sleep_i,
  input  logic   valid_hit_i,
  input  logic   term_hit_i,
  input  logic   det_hit_i,
  input  logic   rch_hit_i,
  input  logic   wake_hit_i,
  input  logic   safe_exp_i,
  output phase_e phase_o
);
  always_comb begin
    phase_o = phase_i;
    if (!vbus_ok_i) begin
      phase_o = PH_WAIT;
    end else if (phase_i == PH_WAIT) begin
      if (valid_hit_i) phase_o = blocked_i ? PH_OFF : PH_PRE;
    end else if (blocked_i) begin
      phase_o = PH_OFF;
    end else begin
      unique case (phase_i)
        PH_OFF:   phase_o = PH_PRE;
        PH_PRE: begin
          if (safe_exp_i)       phase_o = PH_FAULT;
          else if (sleep_i)     phase_o = PH_SLEEP;
          else if (!bat_short_i) phase_o = PH_FAST;
        end
        PH_FAST: begin
          if (safe_exp_i)       phase_o = PH_FAULT;
          else if (sleep_i)     phase_o = PH_SLEEP;
          else if (bat_short_i) phase_o = PH_PRE;
          else if (term_hit_i)  phase_o = PH_DET;
        end
        PH_DET:   if (det_hit_i) phase_o = PH_DONE;
        PH_DONE: begin
          if (sleep_i)          phase_o = PH_SLEEP;
          else if (rch_hit_i)   phase_o = PH_PRE;
        end
        PH_SLEEP: if (wake_hit_i) phase_o = PH_PRE;
        PH_FAULT: phase_o = PH_FAULT;
        default:  phase_o = PH_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/cell_chg_seq.sv
module cell_chg_seq
  import cell_chg_seq_pkg::*;
#(
  parameter int unsigned VALID_MS = 30,
  parameter int unsigned TERM_MS  = 30,
  parameter int unsigned DET_MS   = 262,
  parameter int unsigned RCH_MS   = 130,
  parameter int unsigned SLP_MS   = 30,
  parameter int unsigned SAFE_MS  = 900000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic vbus_ok_i,
  input  logic bat_short_i,
  input  logic bat_rch_i,
  input  logic iterm_low_i,
  input  logic sleep_i,
  input  logic dis_i,
  input  logic ce_n_i,
  input  logic hz_i,
  input  logic te_i,
  output logic lin_en_o,
  output logic pwm_en_o,
  output logic det_en_o,
  output logic stat_n_o
);
  localparam int unsigned NDG = 5;
  localparam int unsigned DG_VALID = 0;
  localparam int unsigned DG_TERM  = 1;
  localparam int unsigned DG_DET   = 2;
  localparam int unsigned DG_RCH   = 3;
  localparam int unsigned DG_WAKE  = 4;
  localparam int unsigned DG_LIM [NDG] = '{VALID_MS, TERM_MS, DET_MS, RCH_MS, SLP_MS};

  phase_e phase_q, phase_d;
  drv_t   drv;

  // Named internal events
  logic [NDG-1:0] dg_arm, dg_hit;
  logic valid_hit, term_hit, det_hit, rch_hit, wake_hit;
  logic safe_run, safe_clr, safe_exp;
  logic blocked;

  assign blocked = hz_i || ce_n_i || dis_i;

  assign dg_arm[DG_VALID] = vbus_ok_i && (phase_q == PH_WAIT);
  assign dg_arm[DG_TERM]  = (phase_q == PH_FAST) && te_i && iterm_low_i;
  assign dg_arm[DG_DET]   = (phase_q == PH_DET);
  assign dg_arm[DG_RCH]   = (phase_q == PH_DONE) && bat_rch_i;
  assign dg_arm[DG_WAKE]  = (phase_q == PH_SLEEP) && !sleep_i;

  for (genvar g = 0; g < NDG; g++) begin : g_dg
    ccs_dglt #(.LIMIT(DG_LIM[g])) u_dg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .arm_i  (dg_arm[g]),
      .hit_o  (dg_hit[g])
    );
  end

  assign valid_hit = dg_hit[DG_VALID];
  assign term_hit  = dg_hit[DG_TERM];
  assign det_hit   = dg_hit[DG_DET];
  assign rch_hit   = dg_hit[DG_RCH];
  assign wake_hit  = dg_hit[DG_WAKE];

  assign safe_run = phase_charging(phase_q);
  assign safe_clr = dis_i || !vbus_ok_i || (phase_q == PH_FAULT);

  ccs_safety #(.LIMIT(SAFE_MS)) u_safe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run_i    (safe_run),
    .clr_i    (safe_clr),
    .expire_o (safe_exp)
  );

  ccs_next u_next (
    .phase_i     (phase_q),
    .vbus_ok_i   (vbus_ok_i),
    .blocked_i   (blocked),
    .bat_short_i (bat_short_i),
    .sleep_i     (sleep_i),
    .valid_hit_i (valid_hit),
    .term_hit_i  (term_hit),
    .det_hit_i   (det_hit),
    .rch_hit_i   (rch_hit),
    .wake_hit_i  (wake_hit),
    .safe_exp_i  (safe_exp),
    .phase_o     (phase_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_WAIT;
    else         phase_q <= phase_d;
  end

  assign drv      = phase_drive(phase_q);
  assign lin_en_o = drv.lin;
  assign pwm_en_o = drv.pwm;
  assign det_en_o = drv.det;
  assign stat_n_o = !phase_charging(phase_q);
endmodule

// File: rtl/cell_chg_seq_chk.sv
module cell_chg_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic vbus_ok_i,
  input logic bat_short_i,
  input logic iterm_low_i,
  input logic sleep_i,
  input logic hz_i,
  input logic te_i,
  input logic lin_en_o,
  input logic pwm_en_o,
  input logic det_en_o,
  input logic stat_n_o
);
  // R1
  supply_loss_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vbus_ok_i |=> !(lin_en_o || pwm_en_o || det_en_o));

  // R6
  hz_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hz_i |=> !(lin_en_o || pwm_en_o || det_en_o));

  // R2
  pwm_needs_no_short_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_en_o |-> !$past(bat_short_i));

  // R3
  term_needs_te_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_en_o) |-> ($past(te_i) && $past(iterm_low_i)));

  // R4
  det_after_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_en_o) |-> $past(pwm_en_o));

  // R9
  sleep_stops_pwm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !pwm_en_o);

  // R10
  stat_tracks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_n_o == !(lin_en_o || pwm_en_o));

  // R10
  one_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lin_en_o, pwm_en_o, det_en_o}));
endmodule

bind cell_chg_seq cell_chg_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vbus_ok_i   (vbus_ok_i),
  .bat_short_i (bat_short_i),
  .iterm_low_i (iterm_low_i),
  .sleep_i     (sleep_i),
  .hz_i        (hz_i),
  .te_i        (te_i),
  .lin_en_o    (lin_en_o),
  .pwm_en_o    (pwm_en_o),
  .det_en_o    (det_en_o),
  .stat_n_o    (stat_n_o)
);

// File: tb/cell_chg_seq_tb.sv
`timescale 1ns/1ps
module cell_chg_seq_tb;
  localparam int unsigned VALID = 8, TERM = 6, DETW = 10, RCH = 7, SLP = 5, SAFE = 120;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b1;
  logic vbus = 1'b0, shrt = 1'b0, low = 1'b0, rch = 1'b0, slp = 1'b0;
  logic dis = 1'b0, ce_n = 1'b0, hz = 1'b0, te = 1'b1;
  logic lin, pwm, det, stat_n;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cell_chg_seq #(
    .VALID_MS(VALID), .TERM_MS(TERM), .DET_MS(DETW),
    .RCH_MS(RCH), .SLP_MS(SLP), .SAFE_MS(SAFE)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .vbus_ok_i(vbus),
    .bat_short_i(shrt), .bat_rch_i(rch), .iterm_low_i(low), .sleep_i(slp),
    .dis_i(dis), .ce_n_i(ce_n), .hz_i(hz), .te_i(te),
    .lin_en_o(lin), .pwm_en_o(pwm), .det_en_o(det), .stat_n_o(stat_n)
  );

  // {req 4, cycles 8, inputs {vbus,short,low,rch,sleep,te,hz,ce_n,dis} 9, expect {lin,pwm,det,stat_n} 4}
  localparam int NV = 26;
  localparam logic [24:0] VEC [NV] = '{
    {4'd1,  8'd3,  9'b010001000, 4'b0001}, // R1 no supply
    {4'd1,  8'd5,  9'b110001000, 4'b0001}, // R1 still validating
    {4'd2,  8'd6,  9'b110001000, 4'b1000}, // R2 precharge only
    {4'd2,  8'd2,  9'b100001000, 4'b0100}, // R2 PWM after short clears
    {4'd3,  8'd3,  9'b101001000, 4'b0100}, // R3 partial low current
    {4'd3,  8'd2,  9'b100001000, 4'b0100}, // R3 drop reloads
    {4'd3,  8'd5,  9'b101001000, 4'b0100}, // R3 not yet
    {4'd4,  8'd4,  9'b101001000, 4'b0011}, // R4 detection sink on
    {4'd4,  8'd5,  9'b100001000, 4'b0011}, // R4 window still open
    {4'd4,  8'd6,  9'b100001000, 4'b0001}, // R4 done
    {4'd5,  8'd4,  9'b100101000, 4'b0001}, // R5 partial recharge flag
    {4'd5,  8'd1,  9'b100001000, 4'b0001}, // R5 drop reloads
    {4'd5,  8'd6,  9'b100101000, 4'b0001}, // R5 not yet
    {4'd5,  8'd4,  9'b100101000, 4'b0100}, // R5 new cycle
    {4'd9,  8'd2,  9'b100010000, 4'b0001}, // R9 sleep
    {4'd9,  8'd4,  9'b100001000, 4'b0001}, // R9 wake window open
    {4'd9,  8'd3,  9'b100001000, 4'b0100}, // R9 resumed
    {4'd6,  8'd2,  9'b100001100, 4'b0001}, // R6 high impedance
    {4'd6,  8'd3,  9'b100001000, 4'b0100}, // R6 restart
    {4'd3,  8'd20, 9'b101000000, 4'b0100}, // R3 te=0 holds charging
    {4'd7,  8'd2,  9'b100001010, 4'b0001}, // R7 charge enable off
    {4'd7,  8'd3,  9'b100001000, 4'b0100}, // R7 restart
    {4'd7,  8'd2,  9'b100001001, 4'b0001}, // R7 disable pin
    {4'd7,  8'd3,  9'b110001000, 4'b1000}, // R7 restart into precharge
    {4'd1,  8'd2,  9'b010001000, 4'b0001}, // R1 supply lost
    {4'd1,  8'd4,  9'b110001000, 4'b0001}  // R1 revalidating
  };

  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {lin, pwm, det, stat_n};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    {vbus, shrt, low, rch, slp, hz, ce_n, dis} = '0;
    te = 1'b1;
    tick = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Reset state (R10 status high during reset)
    repeat (2) @(negedge clk);
    chk("R10 reset", 4'b0001);
    do_reset();

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      {vbus, shrt, low, rch, slp, te, hz, ce_n, dis} = v[12:4];
      run(int'(v[20:13]));
      chk($sformatf("R%0d vec%0d", v[24:21], i), v[3:0]);
    end

    // R1 exact validation boundary
    do_reset();
    vbus = 1'b1; shrt = 1'b1;
    run(VALID);
    chk("R1 boundary before", 4'b0001);
    run(1);
    chk("R10 status low in precharge", 4'b1000);

    // R11 no tick, no progress
    do_reset();
    tick = 1'b0; vbus = 1'b1; shrt = 1'b1;
    run(40);
    chk("R11 tick held low", 4'b0001);
    tick = 1'b1;
    run(VALID + 1);
    chk("R11 tick resumed", 4'b1000);

    // R8 safety timer
    do_reset();
    vbus = 1'b1; te = 1'b0;
    run(VALID + 2);
    chk("R8 fast charge", 4'b0100);
    run(100);
    chk("R8 below limit", 4'b0100);
    dis = 1'b1; run(2);
    chk("R7 disable pin off", 4'b0001);
    dis = 1'b0; run(3);
    chk("R8 restart after pin", 4'b0100);
    run(100);
    chk("R8 pin cleared timer", 4'b0100);
    run(30);
    chk("R8 expired fault", 4'b0001);
    ce_n = 1'b1; run(2);
    ce_n = 1'b0; run(3);
    chk("R8 restart from fault", 4'b0100);
    run(100);
    chk("R8 below limit again", 4'b0100);
    ce_n = 1'b1; run(2);
    ce_n = 1'b0; run(3);
    chk("R8 enable toggle restart", 4'b0100);
    run(30);
    chk("R8 enable toggle kept time", 4'b0001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule